// File: doc/BRIEF.md
# Register-Format Integer ALU with Function Decode

This block is the integer execute stage for register-to-register instructions of a 32-bit RISC core. It takes the raw instruction word and the two source register values read for it, the first source and the second source. It recognises the all-zero major opcode, decodes the 6-bit function field, and computes one of sixteen arithmetic, logical, compare or shift results. The result is captured together with the destination register index and a write-enable.

It also raises one of three exclusive flags in the same registered stage. A signed-overflow trap is raised by the trapping add and subtract. An unsupported flag is raised for the function codes owned by other units: multiply and divide, the high/low moves, register jumps, and the system call and breakpoint codes. An illegal flag is raised for any other code. Whenever a flag is raised, the write-enable stays low, so the register file is never written by a faulting instruction.

Top module: `rtype_alu`

## Requirements
- R1: When bits 31:26 of the instruction are not 000000, the next cycle shows the write-enable low and all three flags low.
- R2: Function 100000 (add) and 100001 (addu) write the 32-bit wrapped sum of first plus second source. Function 100010 (sub) and 100011 (subu) write first minus second. The unsigned forms never raise overflow.
- R3: When add or sub overflows as a signed operation, the overflow flag is set and the write-enable is low.
- R4: Function 100100 writes AND, 100101 writes OR, 100110 writes XOR and 100111 writes NOR of the two sources.
- R5: Function 101010 writes 1 when the first source is less than the second as signed values, and 0 otherwise. Function 101011 makes the same comparison as unsigned values.
- R6: Functions 000000 (left), 000010 (logical right) and 000011 (arithmetic right) shift the second source by the amount in instruction bits 10:6.
- R7: Functions 000100, 000110 and 000111 apply the same three shifts using the low 5 bits of the first source as the amount. The upper bits of the first source are ignored.
- R8: Arithmetic right shifts fill vacated bits with bit 31 of the second source. Logical right shifts fill them with zeros.
- R9: Functions 001000, 001001, 001100, 001101, 010000 to 010011 and 011000 to 011011 set the unsupported flag with the write-enable low.
- R10: Any other function code sets the illegal flag with the write-enable low.
- R11: A supported operation other than the three constant-amount shifts, with a non-zero bits 10:6, sets the illegal flag with the write-enable low.
- R12: Result, destination index (instruction bits 15:11), write-enable and flags appear one clock edge after the inputs. At most one of write-enable, overflow, illegal and unsupported is high.
- R13: A synchronous active-high reset clears the write-enable, the flags, the result and the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word |
| src_a | input | XLEN | First source register value |
| src_b | input | XLEN | Second source register value |
| res_q | output | XLEN | Registered result |
| dest_q | output | 5 | Registered destination register index |
| wen_q | output | 1 | Registered write-enable |
| ovf_q | output | 1 | Registered signed-overflow trap |
| ill_q | output | 1 | Registered illegal-function error |
| uns_q | output | 1 | Registered unsupported-function flag |

## Verification
The bench builds the block with its default XLEN of 32, so the shift amount is 5 bits wide. Every constant and variable shift amount from 0 to 31 lies within reach of the random sweep. The extreme values 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF are fed to every one of the sixteen supported codes. This drives both signed-overflow boundaries, the sign-fill of the arithmetic shifts, and the point where the signed and unsigned comparisons disagree. Separate vectors cover the unsupported group, undefined codes, a stray shift field and a non-zero major opcode.

// File: rtl/rtype_alu.sv
`timescale 1ns/1ps
module rtype_alu #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic [XLEN-1:0] res_q,
  output logic [4:0]      dest_q,
  output logic            wen_q,
  output logic            ovf_q,
  output logic            ill_q,
  output logic            uns_q
);
  localparam int SHW = $clog2(XLEN);

  logic [5:0] funct;
  logic [4:0] sa;
  logic       is_r;
  logic       const_shift;
  logic [SHW-1:0] amt;
  logic [XLEN-1:0] sum, diff, res;
  logic add_ovf, sub_ovf;
  logic ovf_c, ill_c, uns_c;

  assign funct       = instr[5:0];
  assign sa          = instr[10:6];
  assign is_r        = instr[31:26] == 6'b000000;
  assign const_shift = (funct == 6'b000000) || (funct == 6'b000010) || (funct == 6'b000011);
  assign amt         = funct[2] ? src_a[SHW-1:0] : sa[SHW-1:0];
  assign sum         = src_a + src_b;
  assign diff        = src_a - src_b;
  assign add_ovf     = (src_a[XLEN-1] == src_b[XLEN-1]) && (sum[XLEN-1] != src_a[XLEN-1]);
  assign sub_ovf     = (src_a[XLEN-1] != src_b[XLEN-1]) && (diff[XLEN-1] != src_a[XLEN-1]);

  always_comb begin
    res   = '0;
    ovf_c = 1'b0;
    ill_c = 1'b0;
    uns_c = 1'b0;
    case (funct)
      6'b100000: begin res = sum;  ovf_c = add_ovf; end
      6'b100001: res = sum;
      6'b100010: begin res = diff; ovf_c = sub_ovf; end
      6'b100011: res = diff;
      6'b100100: res = src_a & src_b;
      6'b100101: res = src_a | src_b;
      6'b100110: res = src_a ^ src_b;
      6'b100111: res = ~(src_a | src_b);
      6'b101010: res = {{(XLEN-1){1'b0}}, $signed(src_a) < $signed(src_b)};
      6'b101011: res = {{(XLEN-1){1'b0}}, src_a < src_b};
      6'b000000, 6'b000100: res = src_b << amt;
      6'b000010, 6'b000110: res = src_b >> amt;
      6'b000011, 6'b000111: res = $unsigned($signed(src_b) >>> amt);
      6'b001000, 6'b001001, 6'b001100, 6'b001101,
      6'b010000, 6'b010001, 6'b010010, 6'b010011,
      6'b011000, 6'b011001, 6'b011010, 6'b011011: uns_c = 1'b1;
      default: ill_c = 1'b1;
    endcase
    if (!uns_c && !ill_c && !const_shift && sa != 5'd0) begin
      ill_c = 1'b1;
      ovf_c = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      dest_q <= '0;
      wen_q  <= 1'b0;
      ovf_q  <= 1'b0;
      ill_q  <= 1'b0;
      uns_q  <= 1'b0;
    end else begin
      res_q  <= res;
      dest_q <= instr[15:11];
      wen_q  <= is_r && !ovf_c && !ill_c && !uns_c;
      ovf_q  <= is_r && ovf_c;
      ill_q  <= is_r && ill_c;
      uns_q  <= is_r && uns_c;
    end
  end

  // R12
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wen_q, ovf_q, ill_q, uns_q}));

  // R1
  no_write_on_other_opcode_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] != 6'b000000) |=> !wen_q && !ovf_q && !ill_q && !uns_q);

  // R3
  ovf_source_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> ($past(instr[5:0]) == 6'b100000 || $past(instr[5:0]) == 6'b100010));

  // R5
  slt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (is_r && instr[5:1] == 5'b10101 && sa == 5'd0) |=> (wen_q && res_q[XLEN-1:1] == '0));

  // R12
  dest_index_chk: assert property (@(posedge clk) disable iff (rst)
    wen_q |-> dest_q == $past(instr[15:11]));
endmodule

// File: tb/rtype_alu_bench.sv
`timescale 1ns/1ps
module rtype_alu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [31:0] res_q;
  logic [4:0]  dest_q;
  logic        wen_q, ovf_q, ill_q, uns_q;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  rtype_alu #(.XLEN(32)) u_rtype_alu (
    .clk(clk), .rst(rst), .instr(instr), .src_a(src_a), .src_b(src_b),
    .res_q(res_q), .dest_q(dest_q), .wen_q(wen_q), .ovf_q(ovf_q),
    .ill_q(ill_q), .uns_q(uns_q)
  );

  // {instr, src_a, src_b, expected result, expected {wen,ovf,ill,uns}}
  localparam logic [131:0] VEC [18] = '{
    {6'd0,5'd1,5'd2,5'd3,5'd0,6'b100000, 32'h5,        32'h7,        32'hC,        4'b1000}, // R2
    {6'd0,5'd1,5'd2,5'd3,5'd0,6'b100000, 32'h7FFFFFFF, 32'h1,        32'h0,        4'b0100}, // R3
    {6'd0,5'd1,5'd2,5'd3,5'd0,6'b100001, 32'h7FFFFFFF, 32'h1,        32'h80000000, 4'b1000}, // R2
    {6'd0,5'd1,5'd2,5'd3,5'd0,6'b100010, 32'h80000000, 32'h1,        32'h0,        4'b0100}, // R3
    {6'd0,5'd1,5'd2,5'd3,5'd0,6'b100011, 32'h0,        32'h1,        32'hFFFFFFFF, 4'b1000}, // R2
    {6'd0,5'd1,5'd2,5'd3,5'd0,6'b100100, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 4'b1000}, // R4
    {6'd0,5'd1,5'd2,5'd3,5'd0,6'b100111, 32'h0,        32'h0,        32'hFFFFFFFF, 4'b1000}, // R4
    {6'd0,5'd1,5'd2,5'd3,5'd0,6'b101010, 32'hFFFFFFFF, 32'h1,        32'h1,        4'b1000}, // R5
    {6'd0,5'd1,5'd2,5'd3,5'd0,6'b101011, 32'hFFFFFFFF, 32'h1,        32'h0,        4'b1000}, // R5
    {6'd0,5'd0,5'd2,5'd3,5'd31,6'b000000,32'h0,        32'h1,        32'h80000000, 4'b1000}, // R6
    {6'd0,5'd0,5'd2,5'd3,5'd4,6'b000011, 32'h0,        32'h80000000, 32'hF8000000, 4'b1000}, // R8
    {6'd0,5'd0,5'd2,5'd3,5'd4,6'b000010, 32'h0,        32'h80000000, 32'h08000000, 4'b1000}, // R8
    {6'd0,5'd1,5'd2,5'd3,5'd0,6'b000111, 32'hFFFFFFE4, 32'h80000000, 32'hF8000000, 4'b1000}, // R7
    {6'd0,5'd1,5'd2,5'd3,5'd0,6'b000110, 32'h00000021, 32'h80000000, 32'h40000000, 4'b1000}, // R7
    {6'd0,5'd1,5'd2,5'd3,5'd0,6'b011000, 32'h3,        32'h4,        32'h0,        4'b0001}, // R9
    {6'd0,5'd1,5'd2,5'd3,5'd0,6'b111111, 32'h3,        32'h4,        32'h0,        4'b0010}, // R10
    {6'd0,5'd1,5'd2,5'd3,5'd1,6'b100000, 32'h3,        32'h4,        32'h0,        4'b0010}, // R11
    {6'b001000,5'd1,5'd2,5'd3,5'd0,6'b100000, 32'h3,   32'h4,        32'h0,        4'b0000}  // R1
  };

  localparam logic [5:0] FUNCS [16] = '{6'b100000, 6'b100001, 6'b100010, 6'b100011,
    6'b100100, 6'b100101, 6'b100110, 6'b100111, 6'b101010, 6'b101011,
    6'b000000, 6'b000010, 6'b000011, 6'b000100, 6'b000110, 6'b000111};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic void ref_model(input logic [5:0] f, input logic [4:0] sa,
      input logic [31:0] a, input logic [31:0] b,
      output logic [31:0] r, output logic [3:0] fl);
    longint sa_l, sb_l, wide;
    int k;
    sa_l = longint'($signed(a));
    sb_l = longint'($signed(b));
    k = (f[2]) ? int'(a[4:0]) : int'(sa);
    fl = 4'b1000;
    r = 32'h0;
    case (f)
      6'b100000: begin wide = sa_l + sb_l; r = a + b;
                 if (wide > 64'sd2147483647 || wide < -64'sd2147483648) fl = 4'b0100; end
      6'b100001: r = a + b;
      6'b100010: begin wide = sa_l - sb_l; r = a - b;
                 if (wide > 64'sd2147483647 || wide < -64'sd2147483648) fl = 4'b0100; end
      6'b100011: r = a - b;
      6'b100100: r = a & b;
      6'b100101: r = a | b;
      6'b100110: r = a ^ b;
      6'b100111: r = ~(a | b);
      6'b101010: r = (sa_l < sb_l) ? 32'd1 : 32'd0;
      6'b101011: r = (a < b) ? 32'd1 : 32'd0;
      6'b000000, 6'b000100: r = b << k;
      6'b000010, 6'b000110: r = b >> k;
      default: begin
        r = b;
        for (int i = 0; i < k; i++) r = {b[31], r[31:1]};
      end
    endcase
  endfunction

  task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    instr = i; src_a = a; src_b = b;
    @(negedge clk);
  endtask

  initial begin
    #(20ns * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] corner [4];
    logic [31:0] r_exp;
    logic [3:0]  f_exp;
    corner = '{32'h0, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 wen after reset", {31'b0, wen_q}, 32'h0);
    check("R13 flags after reset", {29'b0, ovf_q, ill_q, uns_q}, 32'h0);
    check("R13 result after reset", res_q, 32'h0);
    rst = 1'b0;

    for (int v = 0; v < 18; v++) begin
      apply(VEC[v][131:100], VEC[v][99:68], VEC[v][67:36]);
      check($sformatf("vector %0d flags (R1 R3 R9 R10 R11)", v),
            {28'b0, wen_q, ovf_q, ill_q, uns_q}, {28'b0, VEC[v][3:0]});
      if (VEC[v][3]) begin
        check($sformatf("vector %0d result (R2 R4 R5 R6 R7 R8)", v), res_q, VEC[v][35:4]);
        check($sformatf("vector %0d dest R12", v), {27'b0, dest_q}, 32'd3);
      end
    end

    for (int f = 0; f < 16; f++) begin
      for (int x = 0; x < 8; x++) begin
        for (int y = 0; y < 8; y++) begin
          logic [31:0] a, b;
          logic [4:0]  s;
          logic [4:0]  rd;
          a  = (x < 4) ? corner[x] : $urandom;
          b  = (y < 4) ? corner[y] : $urandom;
          s  = (FUNCS[f] inside {6'b000000, 6'b000010, 6'b000011}) ? 5'($urandom) : 5'd0;
          rd = 5'($urandom);
          ref_model(FUNCS[f], s, a, b, r_exp, f_exp);
          apply({6'd0, 5'd7, 5'd9, rd, s, FUNCS[f]}, a, b);
          check($sformatf("sweep f=%b flags R2 R3", FUNCS[f]),
                {28'b0, wen_q, ovf_q, ill_q, uns_q}, {28'b0, f_exp});
          if (f_exp[3]) begin
            check($sformatf("sweep f=%b result R4 R5 R6 R7 R8", FUNCS[f]), res_q, r_exp);
            check("sweep dest R12", {27'b0, dest_q}, {27'b0, rd});
          end
        end
      end
    end

    // R12 latency: output holds until the next edge
    apply({6'd0, 5'd1, 5'd2, 5'd4, 5'd0, 6'b100101}, 32'h00F0, 32'h0F00);
    @(negedge clk);
    instr = {6'd0, 5'd1, 5'd2, 5'd5, 5'd0, 6'b100110};
    src_a = 32'hFFFF; src_b = 32'h00FF;
    #1;
    check("R12 result before edge", res_q, 32'h0FF0);
    @(negedge clk);
    check("R12 result after edge", res_q, 32'hFF00);
    check("R12 dest after edge", {27'b0, dest_q}, 32'd5);

    // R13 reset mid-run clears registered state
    rst = 1'b1;
    @(negedge clk);
    check("R13 wen cleared", {31'b0, wen_q}, 32'h0);
    check("R13 result cleared", res_q, 32'h0);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule